// File: doc/BRIEF.md
# Configurable UART Transmit Engine

This block takes bytes from an external transmit FIFO and shifts them out on a single serial line. Bit timing comes from a programmable divisor. The divisor produces a tick at sixteen times the baud rate, and each bit on the line lasts sixteen of those ticks.

The frame format is chosen at run time:
- one or two stop bits;
- no parity, even parity or odd parity.

An enable input decides whether new frames may start. While the engine is idle and the enable is high, it pops one byte as soon as the FIFO reports data. It then copies the stop and parity settings and the divisor into its own registers and sends the complete frame.

Top module: `uart_tx_engine`

## Requirements
- R1: While `rst_n` is low, and after reset until the first frame, `txd` is 1 and `fifo_rd` is 0.
- R2: `fifo_rd` is a one-cycle pulse. It is high only in a cycle where the engine is idle, `tx_en` is 1 and `fifo_empty` is 0. The byte on `fifo_data` in that cycle is the one transmitted.
- R3: A frame begins in the cycle after the pop with a start bit of 0. The 8 data bits follow, least significant bit first.
- R4: Every bit of a frame, including start, parity and stop bits, stays on `txd` for exactly 16*D clock cycles. D is `baud_div`, and a value of 0 counts as D=1.
- R5: With `par_mode` 1, a parity bit follows the data bits and makes the number of ones across data and parity even. With `par_mode` 2, the parity bit makes that count odd.
- R6: With `par_mode` 0 or 3, no parity bit is sent, and the stop bits follow the last data bit directly.
- R7: The stop bits are 1. `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R8: While `tx_en` is 0, no frame is started. If `tx_en` drops during a frame, that frame still completes.
- R9: `two_stop`, `par_mode` and `baud_div` are captured in the pop cycle. Changing them during a frame does not alter that frame.
- R10: Between frames `txd` is 1. After the last stop bit, the engine is idle for at least one cycle, and it may pop the next byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Enables the start of new frames |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| par_mode | input | 2 | 0/3: none, 1: even, 2: odd |
| baud_div | input | 12 | Clock cycles per 16x tick (0 counts as 1) |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_rd | output | 1 | One-cycle pop strobe |
| fifo_data | input | 8 | Byte at the head of the FIFO |
| txd | output | 1 | Serial output, high when idle |

## Verification
`fifo_rd` is combinational: it is due in the same cycle as the idle, enabled and non-empty condition. The start bit appears on `txd` one clock edge after the pop. Every later transition comes exactly 16*D edges after the one before it. The final stop bit ends 16*D edges after it began, and `txd` stays high from that edge on.

The bench keeps a behavioural model in step with the design, updated on each rising edge. The model is a queue of bit values, each with a countdown. The design's outputs are compared with the model on every cycle, half a period after the edge, so each result is checked in the exact cycle it is due.

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 12,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              two_stop,
  input  logic [1:0]        par_mode,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              txd
);
  localparam int OVS_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 5);
  localparam logic [IDX_W-1:0] DATA_END = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] PAR_IDX  = IDX_W'(DATA_W + 1);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [OVS_W-1:0]  ovs;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] shd;
  logic              two_q;
  logic [1:0]        par_q;
  logic              par_bit_q;

  logic             par_on;
  logic [IDX_W-1:0] last_idx;
  logic             tick;
  logic             bit_end;

  assign par_on   = (par_q == 2'd1) || (par_q == 2'd2);
  assign last_idx = PAR_IDX + IDX_W'(par_on) + IDX_W'(two_q);
  assign tick     = busy && (cnt == div_q - DIV_W'(1));
  assign bit_end  = tick && (ovs == OVS_W'(OVS - 1));
  assign fifo_rd  = !busy && tx_en && !fifo_empty;

  always_comb begin
    if (!busy)                         txd = 1'b1;
    else if (idx == '0)                txd = 1'b0;
    else if (idx <= DATA_END)          txd = shd[0];
    else if (idx == PAR_IDX && par_on) txd = par_bit_q;
    else                               txd = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      ovs       <= '0;
      cnt       <= '0;
      div_q     <= DIV_W'(1);
      shd       <= '0;
      two_q     <= 1'b0;
      par_q     <= 2'd0;
      par_bit_q <= 1'b0;
    end else if (fifo_rd) begin
      busy      <= 1'b1;
      idx       <= '0;
      ovs       <= '0;
      cnt       <= '0;
      div_q     <= (baud_div == '0) ? DIV_W'(1) : baud_div;
      shd       <= fifo_data;
      two_q     <= two_stop;
      par_q     <= par_mode;
      par_bit_q <= (^fifo_data) ^ (par_mode == 2'd2);
    end else if (busy) begin
      cnt <= tick ? '0 : cnt + DIV_W'(1);
      if (tick) ovs <= ovs + OVS_W'(1);
      if (bit_end) begin
        if (idx == last_idx) busy <= 1'b0;
        else                 idx  <= idx + IDX_W'(1);
        if (idx != '0 && idx <= DATA_END) shd <= shd >> 1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             fifo_empty,
  input logic             fifo_rd,
  input logic             txd,
  input logic             busy,
  input logic             two_q,
  input logic [1:0]       par_q,
  input logic [DIV_W-1:0] div_q
);
  AST_RD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (!busy && tx_en && !fifo_empty)); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !fifo_rd); // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> !txd); // R3
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R10
  AST_NO_POP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !fifo_rd); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(two_q) && $stable(par_q) && $stable(div_q))); // R9
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_q != '0)); // R4
endmodule

bind uart_tx_engine uart_tx_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fifo_empty(fifo_empty),
  .fifo_rd(fifo_rd), .txd(txd), .busy(busy), .two_q(two_q),
  .par_q(par_q), .div_q(div_q)
);

// File: tb/tb_uart_tx_engine.sv
`timescale 1ns/1ps
module tb_uart_tx_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic        two_stop = 1'b0;
  logic [1:0]  par_mode = 2'd0;
  logic [11:0] baud_div = 12'd1;
  logic        fifo_empty = 1'b1;
  logic        fifo_rd;
  logic [7:0]  fifo_data = 8'h00;
  logic        txd;

  uart_tx_engine dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .two_stop(two_stop),
    .par_mode(par_mode), .baud_div(baud_div), .fifo_empty(fifo_empty),
    .fifo_rd(fifo_rd), .fifo_data(fifo_data), .txd(txd)
  );

  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string scen = "";

  logic [7:0] fq[$];
  logic       mq[$];
  string      tq[$];
  bit         m_busy = 0;
  int         mcnt = 0;

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // reference model: advances on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0;
      mq.delete();
      tq.delete();
    end else if (m_busy) begin
      mcnt--;
      if (mcnt == 0) begin
        void'(mq.pop_front());
        void'(tq.pop_front());
        if (mq.size() == 0) m_busy = 0;
        else mcnt = 16 * ((baud_div_lat == 0) ? 1 : baud_div_lat);
      end
    end else if (tx_en && !fifo_empty) begin
      logic [7:0] b;
      b = fq.pop_front();
      baud_div_lat = (baud_div == 0) ? 1 : int'(baud_div);
      mq.push_back(1'b0); tq.push_back("R3");
      for (int i = 0; i < 8; i++) begin
        mq.push_back(b[i]); tq.push_back("R3");
      end
      if (par_mode == 2'd1) begin mq.push_back(^b);  tq.push_back("R5"); end
      if (par_mode == 2'd2) begin mq.push_back(~^b); tq.push_back("R5"); end
      mq.push_back(1'b1); tq.push_back("R7");
      if (two_stop) begin mq.push_back(1'b1); tq.push_back("R7"); end
      m_busy = 1;
      mcnt = 16 * baud_div_lat;
    end
  end

  int baud_div_lat = 1;

  always @(negedge clk) begin
    fifo_empty <= (fq.size() == 0);
    fifo_data  <= (fq.size() == 0) ? 8'h00 : fq[0];
  end

  // compare with the model half a period after each edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic exp_line, exp_rd;
      string t;
      exp_line = m_busy ? mq[0] : 1'b1;
      t = m_busy ? tq[0] : "R10";
      exp_rd = !m_busy && tx_en && !fifo_empty;
      check(txd === exp_line, {t, "/R4", scen}, txd, exp_line);
      check(fifo_rd === exp_rd, {tx_en ? "R2" : "R8", scen}, fifo_rd, exp_rd);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] b);
    fq.push_back(b);
  endtask

  task automatic wait_idle();
    while (fq.size() != 0 || m_busy || !fifo_empty) step(1);
    step(3);
  endtask

  task automatic cfg(input int d, input logic [1:0] pm, input logic ts);
    baud_div = 12'(d);
    par_mode = pm;
    two_stop = ts;
  endtask

  initial begin
    step(1);
    #2;
    check(txd === 1'b1, "R1 reset txd", txd, 1'b1);
    check(fifo_rd === 1'b0, "R1 reset rd", fifo_rd, 1'b0);
    step(2);
    rst_n = 1'b1;
    step(2);
    #2;
    check(txd === 1'b1, "R1 after reset txd", txd, 1'b1);
    step(1);

    scen = "/R8";
    cfg(1, 2'd0, 1'b0);
    push(8'h11); push(8'h22);
    step(100);
    check(fifo_empty === 1'b0, "R8 disabled no pop", fifo_empty, 1'b0);
    fq.delete();
    step(3);

    scen = "/R10";
    tx_en = 1'b1;
    push(8'hA5); push(8'h3C); push(8'hFF);
    wait_idle();

    scen = "/R6";
    cfg(0, 2'd3, 1'b1);
    push(8'h00); push(8'h81);
    wait_idle();

    scen = "/R5";
    cfg(3, 2'd1, 1'b1);
    push(8'h5A); push(8'h01);
    wait_idle();

    cfg(2, 2'd2, 1'b0);
    push(8'h01); push(8'hFE);
    wait_idle();

    scen = "/R6";
    cfg(1, 2'd0, 1'b1);
    push(8'h7E);
    wait_idle();

    scen = "/R9";
    cfg(2, 2'd1, 1'b0);
    push(8'h3B);
    step(40);
    cfg(5, 2'd2, 1'b1);
    wait_idle();

    scen = "/R8";
    cfg(1, 2'd0, 1'b0);
    push(8'hC3); push(8'h96);
    step(30);
    tx_en = 1'b0;
    step(400);
    check(fifo_empty === 1'b0, "R8 second byte held", fifo_empty, 1'b0);
    check(txd === 1'b1, "R8 frame completed", txd, 1'b1);
    tx_en = 1'b1;
    wait_idle();
    check(fifo_empty === 1'b1, "R2 all bytes popped", fifo_empty, 1'b1);

    finish_run();
  end
endmodule